// File: doc/BRIEF.md
# Multicycle Load Sequencer

This block is the control unit for a small multicycle datapath. It runs two instructions. The load instruction computes an address, reads memory into the data holding register, then writes that register into the register file. The load-and-test instruction does the same address and read steps. It then branches on a flag taken from the freshly read word. The block never handles data words itself. It only drives selects and enables, and it watches one flag bit supplied by the datapath.

Every output is decoded from the current state alone. A write enable raised in a state therefore takes effect on the clock edge that ends that state. Because of this, a value read in one state cannot be examined until the following state. The test path passes through a quiet wait state before it samples the flag, and then goes to one of two target states.

Top module: `ldw_ctrl_fsm`

## Requirements
- R1: While rst_ni is low, and in the idle state, all enables and done_o are 0, addr_sel_o is 0 (program counter) and wdata_sel_o is 1 (ALU result).
- R2: The machine leaves idle only on a clock edge where start_i is 1 and opcode_i equals OP_LOAD (default 6'h23) or OP_LTEST (default 6'h24). Any other opcode, or start_i low, keeps all outputs at their idle values.
- R3: For OP_LOAD, the states run one cycle each: address set (alu_ld_o=1), memory read, register write, done, then idle.
- R4: In the memory read state, addr_sel_o=1 and mem_rd_o=1, with all other enables 0. The datapath data register takes the memory word on the edge that ends this state, not earlier.
- R5: In the register write state, wdata_sel_o=0 and reg_wr_o=1. The register file takes the data register's value on the edge that ends this state, not earlier.
- R6: done_o is high for exactly one cycle, in the cycle after the register write or branch-target state. The next cycle is idle.
- R7: Outputs depend on the state only. Changing start_i, opcode_i or flag_i between clock edges leaves every output unchanged.
- R8: For OP_LTEST, the sequence is address set, memory read, then a wait state that shows idle output values. On the edge leaving the wait state, flag_i=1 selects the state with pc_ld_o=1 and flag_i=0 selects the state with pc_inc_o=1. Either target lasts one cycle and is followed by done.
- R9: start_i is ignored while an instruction is in progress.
- R10: At most one of alu_ld_o, mem_rd_o, reg_wr_o, pc_ld_o, pc_inc_o, done_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the instruction given by opcode_i |
| opcode_i | input | OP_W | Instruction opcode |
| flag_i | input | 1 | Flag derived from the read word, sampled in the wait state |
| alu_ld_o | output | 1 | Load the ALU result register (address set) |
| addr_sel_o | output | 1 | Memory address source: 0 = PC, 1 = ALU register |
| mem_rd_o | output | 1 | Memory read; data register captures at end of state |
| wdata_sel_o | output | 1 | Register write data source: 0 = data register, 1 = ALU |
| reg_wr_o | output | 1 | Register file write enable |
| pc_ld_o | output | 1 | Branch target: load PC |
| pc_inc_o | output | 1 | Branch target: step PC |
| done_o | output | 1 | Instruction complete, one cycle |

## Verification
The hardest case to create from the ports is a branch that depends on the word just read. It only proves something if the flag changes exactly on the read edge. The bench models the datapath data register and drives flag_i from its low bit. It preloads that register with the opposite low bit to the memory word. If the machine sampled the flag one state early, it would pick the wrong target. Both flag polarities are run, and the bench also checks that each capture lands one edge after its enable appears.

// File: rtl/ldw_ctrl_pkg.sv
package ldw_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETA  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_WAIT  = 3'd4,
    ST_TAKE  = 3'd5,
    ST_SKIP  = 3'd6,
    ST_DONE  = 3'd7
  } state_e;

  typedef struct packed {
    logic alu_ld;
    logic addr_sel;
    logic mem_rd;
    logic wdata_sel;
    logic reg_wr;
    logic pc_ld;
    logic pc_inc;
    logic done;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{alu_ld: 1'b0, addr_sel: 1'b0, mem_rd: 1'b0,
                                  wdata_sel: 1'b1, reg_wr: 1'b0, pc_ld: 1'b0,
                                  pc_inc: 1'b0, done: 1'b0};
endpackage

// File: rtl/ldw_next_state.sv
module ldw_next_state
  import ldw_ctrl_pkg::*;
#(
  parameter int unsigned     OP_W     = 6,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OP_LTEST = 6'h24
) (
  input  state_e          state_q_i,
  input  logic            test_q_i,
  input  logic            start_i,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            flag_i,
  output state_e          state_d_o,
  output logic            test_d_o
);
  always_comb begin
    state_d_o = state_q_i;
    test_d_o  = test_q_i;
    unique case (state_q_i)
      ST_IDLE: begin
        if (start_i && opcode_i == OP_LOAD) begin
          state_d_o = ST_SETA;
          test_d_o  = 1'b0;
        end else if (start_i && opcode_i == OP_LTEST) begin
          state_d_o = ST_SETA;
          test_d_o  = 1'b1;
        end
      end
      ST_SETA:  state_d_o = ST_READ;
      // read data lands at end of ST_READ; the test path must wait a state
      ST_READ:  state_d_o = test_q_i ? ST_WAIT : ST_WRITE;
      ST_WRITE: state_d_o = ST_DONE;
      ST_WAIT:  state_d_o = flag_i ? ST_TAKE : ST_SKIP;
      ST_TAKE:  state_d_o = ST_DONE;
      ST_SKIP:  state_d_o = ST_DONE;
      ST_DONE:  state_d_o = ST_IDLE;
      default:  state_d_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/ldw_out_decode.sv
module ldw_out_decode
  import ldw_ctrl_pkg::*;
(
  input  state_e state_q_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = CTRL_IDLE;
    unique case (state_q_i)
      ST_SETA:  ctrl_o.alu_ld = 1'b1;
      ST_READ: begin
        ctrl_o.addr_sel = 1'b1;
        ctrl_o.mem_rd   = 1'b1;
      end
      ST_WRITE: begin
        ctrl_o.wdata_sel = 1'b0;
        ctrl_o.reg_wr    = 1'b1;
      end
      ST_TAKE:  ctrl_o.pc_ld  = 1'b1;
      ST_SKIP:  ctrl_o.pc_inc = 1'b1;
      ST_DONE:  ctrl_o.done   = 1'b1;
      default:  ctrl_o = CTRL_IDLE;
    endcase
  end
endmodule

// File: rtl/ldw_ctrl_fsm.sv
module ldw_ctrl_fsm
  import ldw_ctrl_pkg::*;
#(
  parameter int unsigned     OP_W     = 6,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OP_LTEST = 6'h24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            flag_i,
  output logic            alu_ld_o,
  output logic            addr_sel_o,
  output logic            mem_rd_o,
  output logic            wdata_sel_o,
  output logic            reg_wr_o,
  output logic            pc_ld_o,
  output logic            pc_inc_o,
  output logic            done_o
);
  state_e state_q, state_d;
  logic   test_q, test_d;
  ctrl_t  ctrl;

  ldw_next_state #(
    .OP_W    (OP_W),
    .OP_LOAD (OP_LOAD),
    .OP_LTEST(OP_LTEST)
  ) i_next (
    .state_q_i(state_q),
    .test_q_i (test_q),
    .start_i  (start_i),
    .opcode_i (opcode_i),
    .flag_i   (flag_i),
    .state_d_o(state_d),
    .test_d_o (test_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      test_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      test_q  <= test_d;
    end
  end

  ldw_out_decode i_dec (
    .state_q_i(state_q),
    .ctrl_o   (ctrl)
  );

  assign alu_ld_o    = ctrl.alu_ld;
  assign addr_sel_o  = ctrl.addr_sel;
  assign mem_rd_o    = ctrl.mem_rd;
  assign wdata_sel_o = ctrl.wdata_sel;
  assign reg_wr_o    = ctrl.reg_wr;
  assign pc_ld_o     = ctrl.pc_ld;
  assign pc_inc_o    = ctrl.pc_inc;
  assign done_o      = ctrl.done;

  p_onehot_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({alu_ld_o, mem_rd_o, reg_wr_o, pc_ld_o, pc_inc_o, done_o}));

  p_start_from_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alu_ld_o) |-> $past(start_i));

  p_read_after_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_ld_o |=> (mem_rd_o && addr_sel_o));

  p_write_after_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> ($past(mem_rd_o) && !wdata_sel_o));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !alu_ld_o && !mem_rd_o));

  p_branch_after_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_ld_o || pc_inc_o) |-> ($past(mem_rd_o, 2) && !$past(mem_rd_o)));
endmodule

// File: tb/test_ldw_ctrl_fsm.sv
module test_ldw_ctrl_fsm;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_LTEST = 6'h24;
  // {alu_ld, addr_sel, mem_rd, wdata_sel, reg_wr, pc_ld, pc_inc, done}
  localparam logic [7:0] V_IDLE  = 8'h10;
  localparam logic [7:0] V_SETA  = 8'h90;
  localparam logic [7:0] V_READ  = 8'h70;
  localparam logic [7:0] V_WRITE = 8'h08;
  localparam logic [7:0] V_TAKE  = 8'h14;
  localparam logic [7:0] V_SKIP  = 8'h12;
  localparam logic [7:0] V_DONE  = 8'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] opcode = '0;
  logic alu_ld, addr_sel, mem_rd, wdata_sel, reg_wr, pc_ld, pc_inc, done;
  logic [7:0] mem_word = 8'h00;
  logic [7:0] alu_q = 8'hA5;
  logic [7:0] mdr = 8'h00;
  logic [7:0] rf = 8'h00;
  logic [7:0] outv;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  ldw_ctrl_fsm i_ldw_ctrl_fsm (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .flag_i(mdr[0]), .alu_ld_o(alu_ld), .addr_sel_o(addr_sel), .mem_rd_o(mem_rd),
    .wdata_sel_o(wdata_sel), .reg_wr_o(reg_wr), .pc_ld_o(pc_ld),
    .pc_inc_o(pc_inc), .done_o(done)
  );

  assign outv = {alu_ld, addr_sel, mem_rd, wdata_sel, reg_wr, pc_ld, pc_inc, done};

  // datapath model
  always_ff @(posedge clk) begin
    if (mem_rd) mdr <= mem_word;
    if (reg_wr) rf <= wdata_sel ? alu_q : mdr;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 in reset", outv, V_IDLE);
    step();
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", outv, V_IDLE);
  endtask

  task automatic t_bad_ops();
    opcode = 6'h00; start = 1'b1;
    step();
    chk("R2 other opcode", outv, V_IDLE);
    opcode = 6'h22;
    step();
    chk("R2 neighbour opcode", outv, V_IDLE);
    start = 1'b0; opcode = OP_LOAD;
    step();
    chk("R2 no start", outv, V_IDLE);
  endtask

  task automatic t_load(input logic [7:0] word);
    mem_word = word;
    mdr = ~word;
    rf = 8'h00;
    opcode = OP_LOAD; start = 1'b1;
    step();
    start = 1'b0;
    chk("R3 set address", outv, V_SETA);
    step();
    chk("R4 read state", outv, V_READ);
    chk("R4 mdr not yet", mdr, ~word);
    step();
    chk("R5 write state", outv, V_WRITE);
    chk("R4 mdr at end of read", mdr, word);
    chk("R5 rf not yet", rf, 8'h00);
    step();
    chk("R6 done", outv, V_DONE);
    chk("R5 rf at end of write", rf, word);
    step();
    chk("R6 back to idle", outv, V_IDLE);
  endtask

  task automatic t_ltest(input logic fl);
    mem_word = {7'h2C, fl};
    mdr = {7'h00, ~fl};
    opcode = OP_LTEST; start = 1'b1;
    step();
    start = 1'b0;
    chk("R8 set address", outv, V_SETA);
    step();
    chk("R8 read", outv, V_READ);
    step();
    chk("R8 wait quiet", outv, V_IDLE);
    step();
    chk(fl ? "R8 take on flag 1" : "R8 skip on flag 0", outv, fl ? V_TAKE : V_SKIP);
    step();
    chk("R6 done after target", outv, V_DONE);
    step();
    chk("R6 idle after target", outv, V_IDLE);
  endtask

  task automatic t_busy();
    opcode = OP_LOAD; start = 1'b1;
    step();
    chk("R9 set", outv, V_SETA);
    opcode = OP_LTEST;
    step();
    chk("R9 read despite start", outv, V_READ);
    step();
    chk("R9 write despite start", outv, V_WRITE);
    step();
    chk("R9 done despite start", outv, V_DONE);
    start = 1'b0;
    step();
    chk("R9 idle", outv, V_IDLE);
  endtask

  task automatic t_moore();
    opcode = OP_LTEST; start = 1'b1;
    step();
    start = 1'b0;
    step();
    chk("R7 read before wiggle", outv, V_READ);
    #3 start = 1'b1; opcode = OP_LOAD; mdr = 8'hFF;
    #2 chk("R7 read after wiggle", outv, V_READ);
    start = 1'b0; opcode = 6'h00;
    #1 chk("R7 read after second wiggle", outv, V_READ);
    step();
    step();
    step();
    step();
    chk("R7 idle", outv, V_IDLE);
  endtask

  initial begin
    step();
    t_reset();
    t_bad_ops();
    t_load(8'h5B);
    t_load(8'hC2);
    t_ltest(1'b1);
    t_ltest(1'b0);
    t_busy();
    t_moore();
    rst_n = 1'b0;
    #1 chk("R1 async reset", outv, V_IDLE);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule